// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit binary adder. It takes two operands and an incoming carry and returns the 16-bit sum and the outgoing carry. It also returns a block-wide propagate flag and a block-wide generate flag, so that a wider lookahead stage could place it as one of its groups.

The operand width is split into four 4-bit slices. Each slice forms bit-level generate (both bits set) and propagate (either bit set) terms. It computes its own internal carries from fully expanded sum-of-products expressions, so no carry ripples from bit to bit. Each slice also reduces its bit terms into a slice generate and a slice propagate.

A second-level lookahead stage takes those slice terms and the external carry. In flattened form, it produces the carry entering each slice and the final carry-out, so no carry ripples from slice to slice either. Each sum bit is the XOR of the two operand bits and the carry entering that bit.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of the unsigned sum `a_in + b_in + c_in`, for every operand pattern.
- R2: `c_out` equals bit 16 of the 17-bit unsigned sum `a_in + b_in + c_in`.
- R3: `blk_p` is 1 exactly when every bit position has at least one operand bit set, that is when `(a_in | b_in)` is all ones.
- R4: `blk_g` is 1 exactly when `a_in + b_in` produces a carry out of bit 15 with the incoming carry taken as 0. This flag does not depend on `c_in`.
- R5: When every position propagates and none generates (`a_in ^ b_in` all ones), `c_in` passes straight through. With `c_in` = 1 the result is `sum_o` = 0 and `c_out` = 1; with `c_in` = 0 the result is `sum_o` = 0xFFFF and `c_out` = 0.
- R6: When both operands are all ones, `c_out` is 1 whatever `c_in` is, and `sum_o` is 0xFFFE plus `c_in`.
- R7: A carry produced in any 4-bit slice (bits 0-3, 4-7, 8-11, 12-15) reaches every higher bit through the propagating positions, so that a carry crossing each slice boundary gives the correct sum.
- R8: The block holds no state. Outputs are a function of the present inputs only and are valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| c_in | input | 1 | Incoming carry |
| sum_o | output | 16 | Sum bits |
| c_out | output | 1 | Carry out of bit 15 |
| blk_p | output | 1 | Block propagate flag |
| blk_g | output | 1 | Block generate flag |

## Verification
The embedded checks are immediate and are only evaluated once all three inputs carry known 0/1 values. They therefore assume that the driver never presents X or Z on an operand or on the incoming carry, and that inputs change only between samples. The bench sets every input before its first observation and changes them only just after a rising clock edge, then samples on the falling edge. Each check therefore sees fully defined and settled combinational values.

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int GW = 4
) (
  input  logic [15:0] a_in,
  input  logic [15:0] b_in,
  input  logic        c_in,
  output logic [15:0] sum_o,
  output logic        c_out,
  output logic        blk_p,
  output logic        blk_g
);
  localparam int NG = 16 / GW;

  logic [15:0] bg, bp, cb;
  logic [NG-1:0] sg, sp;
  logic [NG:0] cs;

  assign bg = a_in & b_in;
  assign bp = a_in | b_in;

  for (genvar k = 0; k < NG; k++) begin : g_slice
    localparam int B = k * GW;
    logic g0, g1, g2, g3, p0, p1, p2, p3, ci;
    assign g0 = bg[B];   assign p0 = bp[B];
    assign g1 = bg[B+1]; assign p1 = bp[B+1];
    assign g2 = bg[B+2]; assign p2 = bp[B+2];
    assign g3 = bg[B+3]; assign p3 = bp[B+3];
    assign ci = cs[k];

    assign cb[B]   = ci;
    assign cb[B+1] = g0 | (p0 & ci);
    assign cb[B+2] = g1 | (p1 & g0) | (p1 & p0 & ci);
    assign cb[B+3] = g2 | (p2 & g1) | (p2 & p1 & g0) | (p2 & p1 & p0 & ci);

    assign sp[k] = p3 & p2 & p1 & p0;
    assign sg[k] = g3 | (p3 & g2) | (p3 & p2 & g1) | (p3 & p2 & p1 & g0);

    always_comb begin
      if (!$isunknown({a_in, b_in, c_in})) begin
        // R7: each internal carry obeys the single-step recurrence
        a_r7_slice_chain: assert (cb[B+3] == (g2 | (p2 & cb[B+2])))
          else $error("slice carry chain broken");
      end
    end
  end

  assign cs[0] = c_in;
  assign cs[1] = sg[0] | (sp[0] & c_in);
  assign cs[2] = sg[1] | (sp[1] & sg[0]) | (sp[1] & sp[0] & c_in);
  assign cs[3] = sg[2] | (sp[2] & sg[1]) | (sp[2] & sp[1] & sg[0])
               | (sp[2] & sp[1] & sp[0] & c_in);
  assign cs[4] = sg[3] | (sp[3] & sg[2]) | (sp[3] & sp[2] & sg[1])
               | (sp[3] & sp[2] & sp[1] & sg[0])
               | (sp[3] & sp[2] & sp[1] & sp[0] & c_in);

  assign blk_p = &sp;
  assign blk_g = sg[3] | (sp[3] & sg[2]) | (sp[3] & sp[2] & sg[1])
               | (sp[3] & sp[2] & sp[1] & sg[0]);

  assign sum_o = a_in ^ b_in ^ cb;
  assign c_out = cs[NG];

  logic [16:0] ref_sum;
  assign ref_sum = {1'b0, a_in} + {1'b0, b_in} + {16'd0, c_in};

  always_comb begin
    if (!$isunknown({a_in, b_in, c_in})) begin
      a_r1_sum_match: assert (sum_o == ref_sum[15:0])
        else $error("sum mismatch");
      a_r2_carry_match: assert (c_out == ref_sum[16])
        else $error("carry-out mismatch");
      a_r3_prop_bits: assert (!blk_p || (&bp))
        else $error("block propagate without all bits propagating");
      a_r4_gen_forces_carry: assert (!blk_g || c_out)
        else $error("block generate without carry-out");
      a_r7_group_link: assert (cs[2] == (sg[1] | (sp[1] & cs[1])))
        else $error("second-level carry inconsistent");
    end
  end
endmodule

// File: tb/tb_cla16_adder.sv
`timescale 1ns/1ps
module tb_cla16_adder;
  logic clk = 0;
  always #4 clk = ~clk;

  logic [15:0] a, b, s;
  logic ci, co, bpf, bgf;
  int checks = 0, errors = 0;
  bit done = 0;

  cla16_adder dut (.a_in(a), .b_in(b), .c_in(ci), .sum_o(s), .c_out(co),
                   .blk_p(bpf), .blk_g(bgf));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h ci=%b)", tag, act, exp, a, b, ci);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c);
    logic [16:0] r, g0;
    @(posedge clk); a = x; b = y; ci = c;
    @(negedge clk);
    r  = {1'b0, x} + {1'b0, y} + {16'd0, c};
    g0 = {1'b0, x} + {1'b0, y};
    chk("R1 sum", {16'd0, s}, {16'd0, r[15:0]});
    chk("R2 carry", {31'd0, co}, {31'd0, r[16]});
    chk("R3 propagate", {31'd0, bpf}, {31'd0, &(x | y)});
    chk("R4 generate", {31'd0, bgf}, {31'd0, g0[16]});
  endtask

  task automatic t_zero;  // R8: same-cycle result with all-zero inputs
    apply(16'h0000, 16'h0000, 1'b0);
    chk("R8 zero sum", {16'd0, s}, 32'd0);
  endtask

  task automatic t_all_prop;  // R5
    apply(16'hA5A5, 16'h5A5A, 1'b1);
    chk("R5 pass sum", {16'd0, s}, 32'd0);
    chk("R5 pass carry", {31'd0, co}, 32'd1);
    apply(16'hFFFF, 16'h0000, 1'b0);
    chk("R5 hold sum", {16'd0, s}, 32'hFFFF);
    chk("R5 hold carry", {31'd0, co}, 32'd0);
  endtask

  task automatic t_all_gen;  // R6
    for (int c = 0; c < 2; c++) begin
      apply(16'hFFFF, 16'hFFFF, c[0]);
      chk("R6 carry", {31'd0, co}, 32'd1);
      chk("R6 sum", {16'd0, s}, 32'hFFFE + c);
    end
  endtask

  task automatic t_boundaries;  // R7
    for (int k = 0; k < 4; k++) begin
      logic [15:0] m;
      m = 16'hFFFF >> (4 * k);
      apply(16'h000F << (4 * k), m << (4 * k) >> (4 * k) & ~(16'h000F << (4 * k)) | (16'h0001 << (4 * k)), 1'b0);
      chk("R7 slice", {16'd0, s}, {16'd0, a + b});
    end
    apply(16'h7FFF, 16'h0001, 1'b0);
    chk("R7 long chain", {16'd0, s}, 32'h8000);
    apply(16'h0000, 16'hFFFF, 1'b1);
    chk("R7 full chain", {15'd0, co, s}, 32'h10000);
  endtask

  task automatic t_random;
    for (int i = 0; i < 200; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom));
  endtask

  initial begin
    a = 0; b = 0; ci = 0;
    t_zero;
    t_all_prop;
    t_all_gen;
    t_boundaries;
    t_random;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule